// File: doc/BRIEF.md
# Cluster Performance Event Counter Unit

This block counts hardware activity for a processor cluster. It holds a set of 32-bit event counters, up to 31 of them and set by a parameter, and one 64-bit cycle counter. Each event counter has its own event-code register. On every clock the counter looks at a 64-entry vector of single-cycle event pulses, indexed by event code, and adds one when the pulse named by its code is high. The cycle counter advances on every enabled clock.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational. A global control word holds the master enable, two self-clearing reset pulses and read-only identification fields. Three bitmap registers control the counters: counter enable, interrupt enable and overflow status. In each of them event counter n owns bit n and the cycle counter owns bit 31. A counter that wraps sets its sticky overflow bit. The level interrupt stays high while any overflow bit is set together with its interrupt enable. Reading the overflow status returns it and clears it. Two read-only words describe which event codes below 0x40 the hardware implements.

Top module: `cluster_pmu`

## Requirements
- R1: Control word at address 0x00 reads as {implementer[31:24], identification[23:16], number of event counters[15:11], zeros[10:1], global enable[0]}. After reset the global enable is 0, and every counter, bitmap and event-code register is 0.
- R2: An event counter (value at 0x20+n, event code at 0x40+n, code in bits [7:0]) adds one in each cycle in which the global enable is set, its enable bit n at 0x01 is set, and pulse input bit [code] is high.
- R3: While the global enable is clear, no counter changes unless software writes it.
- R4: Clearing a counter's enable bit freezes its value. Setting the bit again resumes counting from that value.
- R5: Code 0x11 counts every enabled cycle without looking at the pulse input. A code at or above 0x40, or a code whose bit in the availability map is clear, never counts.
- R6: The 64-bit cycle counter (low word 0x06, high word 0x07) adds one in each cycle in which the global enable and enable bit 31 are both set.
- R7: A counter that steps from all ones to zero sets its bit in the overflow status at 0x03 (bit n for event counter n, bit 31 for the cycle counter).
- R8: The interrupt output is high exactly while some overflow bit is set and the same bit of the interrupt enable at 0x02 is set.
- R9: A read of 0x03 returns the status and clears it on that clock edge. A wrap in the same cycle leaves its own bit set.
- R10: Writing control bit 1 zeroes all event counters, and writing bit 2 zeroes the cycle counter. Neither bit is stored, so both read back as 0.
- R11: A software write to a counter wins over an increment in the same cycle and causes no overflow.
- R12: Addresses 0x04 and 0x05 return the low and high halves of the 64-bit availability map. Writes to them are ignored.
- R13: Bitmap bits that belong to no implemented counter always read 0. Counter and code addresses beyond the implemented count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_pulse | input | 64 | Single-cycle event pulses, bit index equals event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The checker assumes that a read strobe and a write strobe never occur in the same cycle. It also assumes that the read strobe lasts exactly one clock per intended read, because every cycle with the strobe high clears the status again. The bench drives each register access for a single clock, with an idle clock between accesses. It changes the event pulses only on the falling edge, so every edge sees stable inputs. The cycle-counter properties exclude any cycle that carries a write, because a write may legally load, reset or re-enable the counter.

// File: rtl/cluster_pmu_pkg.sv
package cluster_pmu_pkg;
  localparam int CNT_W     = 32;
  localparam int CYC_W     = 64;
  localparam int CODE_W    = 8;
  localparam int NUM_CODES = 64;
  localparam int CYC_BIT   = 31;
  localparam int MAX_CTR   = 31;

  localparam logic [CODE_W-1:0] CODE_CYCLES = 8'h11;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_CNTEN = 8'h01;
  localparam logic [7:0] A_INTEN = 8'h02;
  localparam logic [7:0] A_OVF   = 8'h03;
  localparam logic [7:0] A_AVLO  = 8'h04;
  localparam logic [7:0] A_AVHI  = 8'h05;
  localparam logic [7:0] A_CYLO  = 8'h06;
  localparam logic [7:0] A_CYHI  = 8'h07;
  localparam logic [2:0] PG_CTR  = 3'b001;
  localparam logic [2:0] PG_TYP  = 3'b010;

  typedef struct packed {
    logic [7:0] impl;
    logic [7:0] ident;
    logic [4:0] nctr;
    logic [7:0] rsvd;
    logic       clr_cyc;
    logic       clr_evt;
    logic       enable;
  } ctrl_word_t;

  // Decide whether a counter programmed with code should count this cycle.
  function automatic logic code_counts(input logic [NUM_CODES-1:0] pulses,
                                       input logic [NUM_CODES-1:0] avail,
                                       input logic [CODE_W-1:0]    code);
    logic hit;
    if (code >= CODE_W'(NUM_CODES))       hit = 1'b0;
    else if (!avail[code[5:0]])           hit = 1'b0;
    else if (code == CODE_CYCLES)         hit = 1'b1;
    else                                  hit = pulses[code[5:0]];
    return hit;
  endfunction

  // The extra top bit of the result is the carry out, which marks a wrap.
  function automatic logic [CNT_W:0] step_evt(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic [CYC_W:0] step_cyc(input logic [CYC_W-1:0] v);
    return {1'b0, v} + {{CYC_W{1'b0}}, 1'b1};
  endfunction

  // Set of bitmap bits that belong to an implemented counter.
  function automatic logic [31:0] live_bits(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < MAX_CTR; i++) if (i < n) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
  import cluster_pmu_pkg::*;
#(
  parameter logic [NUM_CODES-1:0] AVAIL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_wr,
  input  logic                 typ_wr,
  input  logic [CNT_W-1:0]     wdata,
  input  logic [CODE_W-1:0]    typ_data,
  input  logic                 clr,
  input  logic                 run,
  input  logic [NUM_CODES-1:0] pulses,
  output logic [CNT_W-1:0]     cnt,
  output logic [CODE_W-1:0]    typ,
  output logic                 tick,
  output logic                 wrap
);
  logic [CNT_W:0] nxt;

  assign tick = run & code_counts(pulses, AVAIL, typ);
  assign nxt  = step_evt(cnt);
  assign wrap = tick & ~cnt_wr & ~clr & nxt[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      typ <= '0;
    end else begin
      if (cnt_wr)    cnt <= wdata;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= nxt[CNT_W-1:0];
      if (typ_wr)    typ <= typ_data;
    end
  end
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
  import cluster_pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             clr,
  input  logic             run,
  output logic [CYC_W-1:0] cnt,
  output logic             wrap
);
  logic [CYC_W:0] nxt;
  logic           load;

  assign nxt  = step_cyc(cnt);
  assign load = wr_lo | wr_hi;
  assign wrap = run & ~load & ~clr & nxt[CYC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      if (wr_lo) cnt[31:0]      <= wdata;
      if (wr_hi) cnt[CYC_W-1:32] <= wdata;
    end else if (clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= nxt[CYC_W-1:0];
    end
  end
endmodule

// File: rtl/cluster_pmu.sv
module cluster_pmu
  import cluster_pmu_pkg::*;
#(
  parameter int                   NUM_CTR   = 4,
  parameter logic [7:0]           ID_CODE   = 8'h5A,
  parameter logic [7:0]           IMPL_CODE = 8'h41,
  parameter logic [NUM_CODES-1:0] EVT_AVAIL = 64'h0000_00F0_0003_00FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [7:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_CODES-1:0] evt_pulse,
  output logic                 irq
);
  localparam logic [31:0] LIVE = live_bits(NUM_CTR);

  ctrl_word_t  wr_ctl;
  ctrl_word_t  rd_ctl;
  logic        glb_en_q;
  logic [31:0] cnt_en_q, int_en_q, ovf_q;
  logic [31:0] wrap_vec;
  logic [31:0] tick_vec;
  logic        rd_clear;
  logic        ctl_hit, clr_evt, clr_cyc;
  logic [2:0]  page;
  logic [4:0]  slot;
  logic [CYC_W-1:0] cyc_val;
  logic             cyc_wrap;
  logic [CNT_W-1:0]  ctr_val [NUM_CTR];
  logic [CODE_W-1:0] ctr_typ [NUM_CTR];
  logic [NUM_CTR-1:0] ctr_wrap, ctr_tick;

  assign wr_ctl   = ctrl_word_t'(reg_wdata);
  assign page     = reg_addr[7:5];
  assign slot     = reg_addr[4:0];
  assign ctl_hit  = reg_wr && (reg_addr == A_CTRL);
  assign clr_evt  = ctl_hit && wr_ctl.clr_evt;
  assign clr_cyc  = ctl_hit && wr_ctl.clr_cyc;
  assign rd_clear = reg_rd && (reg_addr == A_OVF);

  // One counter slice per implemented event counter.
  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    pmu_evt_ctr #(.AVAIL(EVT_AVAIL)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_wr   (reg_wr && page == PG_CTR && slot == 5'(g)),
      .typ_wr   (reg_wr && page == PG_TYP && slot == 5'(g)),
      .wdata    (reg_wdata),
      .typ_data (reg_wdata[CODE_W-1:0]),
      .clr      (clr_evt),
      .run      (glb_en_q & cnt_en_q[g]),
      .pulses   (evt_pulse),
      .cnt      (ctr_val[g]),
      .typ      (ctr_typ[g]),
      .tick     (ctr_tick[g]),
      .wrap     (ctr_wrap[g])
    );
  end

  pmu_cyc_ctr u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (reg_wr && reg_addr == A_CYLO),
    .wr_hi (reg_wr && reg_addr == A_CYHI),
    .wdata (reg_wdata),
    .clr   (clr_cyc),
    .run   (glb_en_q & cnt_en_q[CYC_BIT]),
    .cnt   (cyc_val),
    .wrap  (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    tick_vec = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      wrap_vec[i] = ctr_wrap[i];
      tick_vec[i] = ctr_tick[i];
    end
    wrap_vec[CYC_BIT] = cyc_wrap;
    tick_vec[CYC_BIT] = glb_en_q & cnt_en_q[CYC_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
      cnt_en_q <= '0;
      int_en_q <= '0;
      ovf_q    <= '0;
    end else begin
      if (ctl_hit)                          glb_en_q <= wr_ctl.enable;
      if (reg_wr && reg_addr == A_CNTEN)    cnt_en_q <= reg_wdata & LIVE;
      if (reg_wr && reg_addr == A_INTEN)    int_en_q <= reg_wdata & LIVE;
      ovf_q <= (rd_clear ? 32'd0 : ovf_q) | wrap_vec;
    end
  end

  assign irq = |(ovf_q & int_en_q);

  always_comb begin
    rd_ctl         = '0;
    rd_ctl.impl    = IMPL_CODE;
    rd_ctl.ident   = ID_CODE;
    rd_ctl.nctr    = 5'(NUM_CTR);
    rd_ctl.enable  = glb_en_q;
    reg_rdata      = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = rd_ctl;
      A_CNTEN: reg_rdata = cnt_en_q;
      A_INTEN: reg_rdata = int_en_q;
      A_OVF:   reg_rdata = ovf_q;
      A_AVLO:  reg_rdata = EVT_AVAIL[31:0];
      A_AVHI:  reg_rdata = EVT_AVAIL[63:32];
      A_CYLO:  reg_rdata = cyc_val[31:0];
      A_CYHI:  reg_rdata = cyc_val[63:32];
      default: begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (page == PG_CTR && slot == 5'(i)) reg_rdata = ctr_val[i];
          if (page == PG_TYP && slot == 5'(i)) reg_rdata = {24'd0, ctr_typ[i]};
        end
      end
    endcase
  end
endmodule

// File: rtl/cluster_pmu_chk.sv
module cluster_pmu_chk
  import cluster_pmu_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [7:0]       reg_addr,
  input logic             irq,
  input logic             glb_en,
  input logic [31:0]      cnt_en,
  input logic [31:0]      int_en,
  input logic [31:0]      ovf,
  input logic [31:0]      wrap_vec,
  input logic [CYC_W-1:0] cyc_cnt
);
  localparam logic [31:0] LIVE = live_bits(NUM_CTR);

  // R6
  cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && cnt_en[CYC_BIT] && !reg_wr) |=> (cyc_cnt == $past(cyc_cnt) + 64'd1));

  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !reg_wr) |=> $stable(cyc_cnt));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_vec[CYC_BIT] |=> ovf[CYC_BIT]);

  // R9
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_OVF && wrap_vec == 32'd0) |=> (ovf == 32'd0));

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((wrap_vec & int_en) != 32'd0) && !reg_wr) |=> irq);

  // R13
  ovf_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf & ~LIVE) == 32'd0));
endmodule

bind cluster_pmu cluster_pmu_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .irq      (irq),
  .glb_en   (glb_en_q),
  .cnt_en   (cnt_en_q),
  .int_en   (int_en_q),
  .ovf      (ovf_q),
  .wrap_vec (wrap_vec),
  .cyc_cnt  (cyc_val)
);

// File: tb/cluster_pmu_tb.sv
module cluster_pmu_tb;
  localparam int          NC = 4;
  localparam bit [63:0]   AV = 64'h0000_00F0_0003_00FF;
  localparam bit [31:0]   VM = ((32'd1 << NC) - 32'd1) | 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] evt_pulse = '0;
  logic        irq;

  bit [63:0] pulse_mask = '0;
  bit [63:0] pulse_force = '0;
  int n_chk = 0, n_fail = 0;
  bit running = 0;

  // Behavioural reference state
  bit        m_gen;
  bit [31:0] m_en, m_ie, m_ovf;
  bit [31:0] m_cnt [NC];
  bit [7:0]  m_typ [NC];
  bit [63:0] m_cyc;

  always #10 clk = ~clk;

  cluster_pmu u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic bit m_hit(input bit [7:0] code, input bit [63:0] p);
    int c;
    c = code;
    if (c > 63) return 0;
    if (AV[c] == 1'b0) return 0;
    if (c == 17) return 1;
    return p[c];
  endfunction

  function automatic bit [31:0] m_read(input bit [7:0] a);
    case (a)
      8'h00: return {8'h41, 8'h5A, 5'(NC), 10'd0, m_gen};
      8'h01: return m_en;
      8'h02: return m_ie;
      8'h03: return m_ovf;
      8'h04: return AV[31:0];
      8'h05: return AV[63:32];
      8'h06: return m_cyc[31:0];
      8'h07: return m_cyc[63:32];
      default: begin
        if (a >= 8'h20 && a < 8'h20 + NC) return m_cnt[a - 8'h20];
        if (a >= 8'h40 && a < 8'h40 + NC) return {24'd0, m_typ[a - 8'h40]};
        return 32'd0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    bit [31:0] wraps;
    bit [31:0] nc [NC];
    bit [63:0] ny;
    int k;
    if (!rst_n) begin
      m_gen = 0; m_en = 0; m_ie = 0; m_ovf = 0; m_cyc = 0;
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
    end else begin
      wraps = 0;
      for (int i = 0; i < NC; i++) begin
        nc[i] = m_cnt[i];
        if (m_gen && m_en[i] && m_hit(m_typ[i], evt_pulse)) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) wraps[i] = 1;
          nc[i] = m_cnt[i] + 1;
        end
      end
      ny = m_cyc;
      if (m_gen && m_en[31]) begin
        if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wraps[31] = 1;
        ny = m_cyc + 1;
      end
      if (reg_wr) begin
        k = reg_addr;
        if (k == 0) begin
          m_gen = reg_wdata[0];
          if (reg_wdata[1]) for (int i = 0; i < NC; i++) begin nc[i] = 0; wraps[i] = 0; end
          if (reg_wdata[2]) begin ny = 0; wraps[31] = 0; end
        end else if (k == 1) m_en = reg_wdata & VM;
        else if (k == 2) m_ie = reg_wdata & VM;
        else if (k == 6) begin ny = {m_cyc[63:32], reg_wdata}; wraps[31] = 0; end
        else if (k == 7) begin ny = {reg_wdata, m_cyc[31:0]}; wraps[31] = 0; end
        else if (k >= 32 && k < 32 + NC) begin nc[k-32] = reg_wdata; wraps[k-32] = 0; end
        else if (k >= 64 && k < 64 + NC) m_typ[k-64] = reg_wdata[7:0];
      end
      for (int i = 0; i < NC; i++) m_cnt[i] = nc[i];
      m_cyc = ny;
      m_ovf = ((reg_rd && reg_addr == 8'h03) ? 32'd0 : m_ovf) | wraps;
    end
  end

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Interrupt compared against the model on every clock
  always @(negedge clk) begin
    if (running) chk("R8 irq", {31'd0, irq}, {31'd0, |(m_ovf & m_ie)});
  end

  always @(negedge clk) evt_pulse = ({$urandom, $urandom} & pulse_mask) | pulse_force;

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input string tag, input bit [7:0] a);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1;
    chk(tag, reg_rdata, m_read(a));
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    running = 1;
    // R1 reset state and identification
    rd("R1 ctrl", 8'h00);
    rd("R1 ovf", 8'h03);
    rd("R1 ctr0", 8'h20);
    rd("R1 cyc", 8'h06);
    // R12 availability map, read-only
    rd("R12 avlo", 8'h04);
    wr(8'h04, 32'h0);
    rd("R12 avlo after write", 8'h04);
    rd("R12 avhi", 8'h05);
    // R13 unimplemented bitmap bits
    wr(8'h01, 32'hFFFF_FFFF);
    rd("R13 cnten", 8'h01);
    wr(8'h02, 32'h8000_0005);
    // R2 / R5 programming
    wr(8'h40, 32'h03); wr(8'h41, 32'h05); wr(8'h42, 32'h11); wr(8'h43, 32'h08);
    rd("R2 type0", 8'h40);
    pulse_mask = '1;
    wr(8'h00, 32'h1);
    idle(50);
    rd("R2 ctr0", 8'h20);
    rd("R2 ctr1", 8'h21);
    rd("R5 cycles code", 8'h22);
    rd("R5 unavailable code", 8'h23);
    rd("R6 cyc lo", 8'h06);
    wr(8'h43, 32'h45);
    idle(20);
    rd("R5 code above range", 8'h23);
    // R3 global enable off
    wr(8'h00, 32'h0);
    idle(20);
    rd("R3 ctr0", 8'h20);
    rd("R3 cyc", 8'h06);
    // R4 per-counter disable
    wr(8'h00, 32'h1);
    wr(8'h01, 32'h8000_0006);
    idle(20);
    rd("R4 ctr0 frozen", 8'h20);
    rd("R4 ctr1", 8'h21);
    // R7 / R9 event counter wrap
    wr(8'h01, 32'h8000_000F);
    pulse_force[3] = 1;
    wr(8'h20, 32'hFFFF_FFFE);
    idle(5);
    rd("R7 ovf after wrap", 8'h03);
    rd("R9 ovf cleared", 8'h03);
    // R7 cycle counter wrap
    wr(8'h07, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFF0);
    idle(30);
    rd("R6 cyc hi after wrap", 8'h07);
    rd("R7 ovf cycle bit", 8'h03);
    // R11 write beats increment
    wr(8'h20, 32'h0000_1234);
    rd("R11 ctr0", 8'h20);
    // R9 wrap coinciding with clearing read (ctr2 counts every cycle)
    rd("R9 pre-clear", 8'h03);
    wr(8'h22, 32'hFFFF_FFFE);
    rd("R9 read during wrap", 8'h03);
    rd("R9 bit kept", 8'h03);
    // R10 reset pulses
    wr(8'h00, 32'h3);
    rd("R10 ctrl readback", 8'h00);
    rd("R10 ctr1", 8'h21);
    wr(8'h00, 32'h5);
    rd("R10 cyc hi", 8'h07);
    rd("R10 cyc lo", 8'h06);
    // R13 addresses beyond implemented counters
    rd("R13 ctr10", 8'h2A);
    rd("R13 typ10", 8'h4A);
    pulse_force = '0;
    pulse_mask = 64'h0000_0000_0000_0028;
    idle(30);
    rd("R2 sparse ctr0", 8'h20);
    rd("R2 sparse ctr1", 8'h21);
    running = 0;
    report();
  end
endmodule